// File: doc/BRIEF.md
# Two-factor I2C bus clock divider

This block turns a fast core clock into the timing reference that an I2C master uses to shape SCL. Software writes one 7-bit factor word, and the block splits it into two fields. A 3-bit exponent n sets a power-of-two prescaler that divides by 2^(n+1). A 4-bit linear factor m sets a second stage that divides the prescaler output by (m+1).

The combined output is a single-cycle oversample tick. It fires once every (m+1)·2^(n+1) enabled core cycles, which is ten times the intended bus rate. A modulo-ten phase counter advances on each tick. It drives two level outputs that tell the bit engine whether SCL is in its low half or its high half. As a result, SCL frequency = core clock / (10·(m+1)·2^(n+1)).

Writing the factor word clears every counter, so the new rate starts from a clean period in the low phase. While the enable input is low, every counter holds its value. The reset factors are parameters. They are normally chosen to give the standard 100 kHz rate for the system core clock.

Top module: `scl_rate_gen`

## Requirements
- R1: During and after reset, before any tick, `os_tick` is 0, `scl_low_en` is 1 and `scl_high_en` is 0. The divider runs with the parameter reset factors: with the defaults (m=4, n=1), the first tick comes 20 enabled cycles after reset is released.
- R2: A factor write takes n from `cfg_data[2:0]` and m from `cfg_data[6:3]`.
- R3: With factors m and n, `os_tick` is a one-cycle pulse that repeats every (m+1)·2^(n+1) enabled cycles.
- R4: `scl_low_en` and `scl_high_en` are complementary. After a restart the SCL phase is low for 5 ticks and then high for 5 ticks, repeating. Both outputs change only in the cycle where `os_tick` rises, or after a write.
- R5: A write (`cfg_wr`=1 at a clock edge) clears all counters. `os_tick` is low in the next cycle, the phase returns to low, and the first tick comes exactly (m+1)·2^(n+1) cycles after the write edge.
- R6: While `enable` is low, no tick is produced and all counters hold their values. When `enable` returns high, counting resumes where it stopped.
- R7: The extreme factors work: m=0,n=0 gives a period of 2 cycles, and m=15,n=7 gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; counters hold while low |
| cfg_wr | input | 1 | Factor word write strobe |
| cfg_data | input | 7 | Factor word: n in [2:0], m in [6:3] |
| os_tick | output | 1 | Oversample tick, ten per SCL period |
| scl_low_en | output | 1 | SCL is in its low phase |
| scl_high_en | output | 1 | SCL is in its high phase |

## Verification
The assertions assume that `enable`, `cfg_wr` and `cfg_data` are synchronous to `clk` and that a write strobe lasts one cycle. They also assume that the phase count is even, so that the low and high halves are the same length. The bench changes every input only at the falling edge. It issues every write as a one-cycle pulse and keeps the default phase count of ten, so the stimulus stays within those assumptions.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int N_W         = 3,
  parameter int M_W         = 4,
  parameter int PHASE_TICKS = 10,
  parameter int RST_N_VAL   = 1,
  parameter int RST_M_VAL   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cfg_wr,
  input  logic [N_W+M_W-1:0] cfg_data,
  output logic               os_tick,
  output logic               scl_low_en,
  output logic               scl_high_en
);
  localparam int PRE_W = 2 ** N_W;
  localparam int PH_W  = $clog2(PHASE_TICKS);
  localparam int HALF  = PHASE_TICKS / 2;
  localparam logic [N_W-1:0] NMAX = '1;

  logic [N_W-1:0]   fac_n;
  logic [M_W-1:0]   fac_m;
  logic [PRE_W-1:0] pre_cnt;
  logic [M_W-1:0]   lin_cnt;
  logic [PH_W-1:0]  ph_cnt;
  logic             tick_q;

  logic [PRE_W-1:0] pre_lim;
  logic             pre_wrap, lin_wrap, tick_i, ph_last;

  assign pre_lim  = {PRE_W{1'b1}} >> (NMAX - fac_n);
  assign pre_wrap = (pre_cnt == pre_lim);
  assign lin_wrap = (lin_cnt == fac_m);
  assign tick_i   = enable & pre_wrap & lin_wrap;
  assign ph_last  = (ph_cnt == PH_W'(PHASE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fac_n   <= N_W'(RST_N_VAL);
      fac_m   <= M_W'(RST_M_VAL);
      pre_cnt <= '0;
      lin_cnt <= '0;
      ph_cnt  <= '0;
      tick_q  <= 1'b0;
    end else if (cfg_wr) begin
      fac_n   <= cfg_data[N_W-1:0];
      fac_m   <= cfg_data[N_W+M_W-1:N_W];
      pre_cnt <= '0;
      lin_cnt <= '0;
      ph_cnt  <= '0;
      tick_q  <= 1'b0;
    end else if (enable) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap)
        lin_cnt <= lin_wrap ? '0 : lin_cnt + 1'b1;
      if (tick_i)
        ph_cnt <= ph_last ? '0 : ph_cnt + 1'b1;
      tick_q <= tick_i;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign os_tick     = tick_q;
  assign scl_low_en  = (ph_cnt < PH_W'(HALF));
  assign scl_high_en = ~scl_low_en;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cfg_wr,
  input logic os_tick,
  input logic scl_low_en,
  input logic scl_high_en
);
  a_r6_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !os_tick);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);

  a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (scl_low_en && !os_tick));

  a_r4_low_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_tick && !$past(cfg_wr)) |-> $stable(scl_low_en));

  a_r4_high_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_high_en) |-> os_tick);

  a_r4_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({scl_low_en, scl_high_en}));
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
  .os_tick(os_tick), .scl_low_en(scl_low_en), .scl_high_en(scl_high_en)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_data = '0;
  logic       os_tick, scl_low_en, scl_high_en;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .os_tick(os_tick),
    .scl_low_en(scl_low_en), .scl_high_en(scl_high_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int m, input int n);
    @(negedge clk);
    cfg_wr   = 1'b1;
    cfg_data = {m[3:0], n[2:0]};
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic cycles_to_tick(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!os_tick && cnt < 10000);
  endtask

  task automatic t_reset;
    int c;
    check(os_tick == 1'b0 && scl_low_en && !scl_high_en, "R1 reset outputs",
          {os_tick, scl_low_en, scl_high_en}, 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    c = 0;
    while (!os_tick && c < 10000) begin
      @(negedge clk);
      c++;
    end
    check(c == 20, "R1 reset factors first tick", c, 20);
  endtask

  task automatic t_period(input int m, input int n, input string req);
    int c;
    int t;
    t = (m + 1) * (2 ** (n + 1));
    write_cfg(m, n);
    check(scl_low_en && !os_tick, "R5 state after write", {scl_low_en, os_tick}, 2'b10);
    c = 0;
    while (!os_tick && c < 10000) begin
      @(negedge clk);
      c++;
    end
    check(c == t, "R5 first tick latency", c, t);
    @(negedge clk);
    check(!os_tick, "R3 pulse width one cycle", os_tick, 0);
    c = 1;
    while (!os_tick && c < 10000) begin
      @(negedge clk);
      c++;
    end
    check(c == t, req, c, t);
  endtask

  task automatic t_phase(input int m, input int n);
    int k;
    write_cfg(m, n);
    check(scl_low_en && !scl_high_en, "R4 starts low", scl_high_en, 0);
    k = 0;
    for (int i = 0; i < 20; i++) begin
      int c;
      cycles_to_tick(c);
      k++;
      check(scl_high_en == ((k % 10) >= 5), "R4 phase after tick", scl_high_en, int'((k % 10) >= 5));
      check(scl_low_en != scl_high_en, "R4 complementary", scl_low_en, int'(!scl_high_en));
    end
  endtask

  task automatic t_hold;
    int c;
    bit lo;
    bit seen;
    write_cfg(2, 1);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    lo = scl_low_en;
    seen = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (os_tick || scl_low_en != lo) seen = 1'b1;
    end
    check(!seen, "R6 no tick and phase held while off", seen, 0);
    enable = 1'b1;
    cycles_to_tick(c);
    check(c == 7, "R6 resume continues count", c, 7);
  endtask

  task automatic t_write_mid_phase;
    int c;
    write_cfg(0, 0);
    for (int i = 0; i < 6; i++) cycles_to_tick(c);
    check(scl_high_en, "R4 high after six ticks", scl_high_en, 1);
    write_cfg(1, 0);
    check(scl_low_en, "R5 write returns phase to low", scl_low_en, 1);
    cycles_to_tick(c);
    check(c == 4, "R5 restart latency", c, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_period(5, 0, "R2 m field in bits 6:3");
    t_period(0, 3, "R2 n field in bits 2:0");
    t_period(2, 1, "R3 period mid factors");
    t_period(0, 0, "R7 minimum period");
    t_period(15, 7, "R7 maximum period");
    t_phase(0, 0);
    t_phase(1, 1);
    t_hold();
    t_write_mid_phase();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule